// File: doc/BRIEF.md
# Release Consistency Ordering Gate

The gate sits between an in-order stream of memory operations and a memory port that may finish operations in any order. Every operation carries a two-bit label: ordinary, special non-sync, acquire or release. It also carries a read/write bit and a tag. Each cycle the gate decides whether the head operation may issue, and signals this on `op_ready_o`. An operation issues in a cycle where `op_valid_i` and `op_ready_o` are both high.

The decision comes from counters of outstanding operations, kept per class: ordinary, special read, special write and acquire. Issue handshakes raise the counters and completion reports lower them. A tag table keeps two operations with the same tag from being in flight together.

A mode input selects the ordering rules:
- In the sequentially consistent flavor, all special operations stay in order with one another.
- In the processor consistent flavor, a special read may pass an earlier special write that has not completed.

Top module: `rc_order_gate`

## Requirements
- R1: Labels are encoded 00 ordinary, 01 special non-sync, 10 acquire, 11 release. Labels other than ordinary are special, and `op_is_write_i` = 1 marks a write. After reset nothing is outstanding, and `op_ready_o` is high for every label and direction.
- R2: While no acquire is outstanding and the tag is free, an ordinary operation is ready whatever ordinary or special operations are outstanding.
- R3: While an acquire is outstanding, `op_ready_o` is low for all labels. It can return high in the cycle after the acquire's completion is accepted.
- R4: A release is ready only when no ordinary, special read or special write is outstanding, in either mode.
- R5: With `mode_pc_i` = 0, a special operation is ready only when no special read and no special write is outstanding.
- R6: With `mode_pc_i` = 1, a special read is ready when no special read is outstanding, even with special writes outstanding. A special write still needs both special counts at zero.
- R7: An acquire does not wait for outstanding ordinary operations. It obeys only the special ordering rules.
- R8: Each class counter holds at most 15. An operation whose class is at 15 outstanding is not ready.
- R9: An operation whose tag is still outstanding is not ready. Completing that tag frees it from the next cycle.
- R10: A completion lowers its class count (taken from `done_label_i`/`done_is_write_i`) from the next cycle. An issue and a completion in the same cycle cancel out in the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_pc_i | input | 1 | 0 sequentially consistent flavor, 1 processor consistent flavor |
| op_valid_i | input | 1 | Head operation present |
| op_ready_o | output | 1 | Head operation may issue this cycle |
| op_label_i | input | 2 | Head label (R1 encoding) |
| op_is_write_i | input | 1 | Head is a write |
| op_tag_i | input | 4 | Head tag |
| done_valid_i | input | 1 | A completion is reported this cycle |
| done_tag_i | input | 4 | Tag of the completing operation |
| done_label_i | input | 2 | Label of the completing operation |
| done_is_write_i | input | 1 | Direction of the completing operation |

## Verification
The bench sweeps every combination of outstanding ordinary, special-read and special-write state against every head label and direction in both modes. A gate that applies the exemption in the wrong mode, or exempts write-after-read instead of read-after-write, fails that sweep. So does a release that ignores ordinary work, or an acquire that waits on ordinary work.

Directed cases cover the following, and each has a distinct symptom when wrong:
- **Acquire blocking:** ready held low until the cycle after completion. A wrong gate lets work slip past the acquire, or stays stuck.
- **Saturation at 15:** a wrong gate wraps a counter to zero and then lets a release through early.
- **Reused tags:** a wrong gate issues the same tag twice.
- **Same-cycle issue with completion:** a wrong gate loses or double counts one of the two.

A long random stream with random completion order then compares `op_ready_o` every cycle against a scoreboard of outstanding operations.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    LBL_ORD   = 2'b00,
    LBL_NSYNC = 2'b01,
    LBL_ACQ   = 2'b10,
    LBL_REL   = 2'b11
  } op_label_e;

  localparam int CLS_ORD = 0;
  localparam int CLS_SRD = 1;
  localparam int CLS_SWR = 2;
  localparam int CLS_ACQ = 3;
  localparam int NUM_CLS = 4;

  // counters an operation of this label/direction occupies
  function automatic logic [NUM_CLS-1:0] class_mask(input logic [1:0] lbl, input logic wr);
    logic [NUM_CLS-1:0] m;
    m = '0;
    if (lbl == LBL_ORD) m[CLS_ORD] = 1'b1;
    else begin
      m[CLS_SRD] = ~wr;
      m[CLS_SWR] = wr;
    end
    if (lbl == LBL_ACQ) m[CLS_ACQ] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rc_class_counter.sv
module rc_class_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             do_inc, do_dec;

  assign do_inc = inc_i && (cnt_q != CntMax);
  assign do_dec = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (do_inc && !do_dec) cnt_q <= cnt_q + 1'b1;
    else if (do_dec && !do_inc) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign full_o = (cnt_q == CntMax);
endmodule

// File: rtl/rc_tag_tracker.sv
module rc_tag_tracker #(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  output logic             probe_busy_o,
  output logic [(1<<TAG_W)-1:0] busy_o
);
  localparam int NumTags = 1 << TAG_W;

  logic [NumTags-1:0] busy_q;

  for (genvar t = 0; t < NumTags; t++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  busy_q[t] <= 1'b0;
      else if (set_i && set_tag_i == TAG_W'(t))     busy_q[t] <= 1'b1;
      else if (clr_i && clr_tag_i == TAG_W'(t))     busy_q[t] <= 1'b0;
    end
  end

  assign probe_busy_o = busy_q[probe_tag_i];
  assign busy_o       = busy_q;
endmodule

// File: rtl/rc_issue_rules.sv
module rc_issue_rules
  import rc_pkg::*;
(
  input  logic               mode_pc_i,
  input  logic [1:0]         label_i,
  input  logic               is_write_i,
  input  logic               tag_busy_i,
  input  logic [NUM_CLS-1:0] zero_i,
  input  logic [NUM_CLS-1:0] full_i,
  output logic               ready_o
);
  logic [NUM_CLS-1:0] need;
  logic is_spec, is_rel, spec_ok, rel_ok, room_ok;

  always_comb begin
    need    = class_mask(label_i, is_write_i);
    is_spec = (label_i != LBL_ORD);
    is_rel  = (label_i == LBL_REL);
    // pc flavor lets a special read pass outstanding special writes
    spec_ok = zero_i[CLS_SRD] && (zero_i[CLS_SWR] || (mode_pc_i && !is_write_i));
    rel_ok  = zero_i[CLS_ORD] && zero_i[CLS_SRD] && zero_i[CLS_SWR];
    room_ok = ~|(need & full_i);
    ready_o = zero_i[CLS_ACQ] && !tag_busy_i && room_ok &&
              (!is_spec || spec_ok) && (!is_rel || rel_ok);
  end
endmodule

// File: rtl/rc_order_gate.sv
module rc_order_gate
  import rc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pc_i,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [1:0]       op_label_i,
  input  logic             op_is_write_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic             done_valid_i,
  input  logic [TAG_W-1:0] done_tag_i,
  input  logic [1:0]       done_label_i,
  input  logic             done_is_write_i
);
  localparam int NumTags = 1 << TAG_W;

  logic               issue;
  logic [NUM_CLS-1:0] inc_v, dec_v, zero_v, full_v;
  logic [CNT_W-1:0]   cnt_v [NUM_CLS];
  logic               tag_busy;
  logic [NumTags-1:0] busy_v;
  logic [CNT_W-1:0]   cnt_ord, cnt_srd, cnt_swr, cnt_acq;

  assign issue = op_valid_i && op_ready_o;
  assign inc_v = issue ? class_mask(op_label_i, op_is_write_i) : '0;
  assign dec_v = done_valid_i ? class_mask(done_label_i, done_is_write_i) : '0;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    rc_class_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc_v[c]),
      .dec_i  (dec_v[c]),
      .cnt_o  (cnt_v[c]),
      .zero_o (zero_v[c]),
      .full_o (full_v[c])
    );
  end

  assign cnt_ord = cnt_v[CLS_ORD];
  assign cnt_srd = cnt_v[CLS_SRD];
  assign cnt_swr = cnt_v[CLS_SWR];
  assign cnt_acq = cnt_v[CLS_ACQ];

  rc_tag_tracker #(.TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (issue),
    .set_tag_i    (op_tag_i),
    .clr_i        (done_valid_i),
    .clr_tag_i    (done_tag_i),
    .probe_tag_i  (op_tag_i),
    .probe_busy_o (tag_busy),
    .busy_o       (busy_v)
  );

  rc_issue_rules u_rules (
    .mode_pc_i  (mode_pc_i),
    .label_i    (op_label_i),
    .is_write_i (op_is_write_i),
    .tag_busy_i (tag_busy),
    .zero_i     (zero_v),
    .full_i     (full_v),
    .ready_o    (op_ready_o)
  );
endmodule

// File: rtl/rc_order_gate_chk.sv
module rc_order_gate_chk #(
  parameter int CNT_W = 4,
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_pc_i,
  input logic             op_valid_i,
  input logic             op_ready_o,
  input logic [1:0]       op_label_i,
  input logic             op_is_write_i,
  input logic [TAG_W-1:0] op_tag_i,
  input logic             done_valid_i,
  input logic [1:0]       done_label_i,
  input logic [CNT_W-1:0] cnt_ord_i,
  input logic [CNT_W-1:0] cnt_srd_i,
  input logic [CNT_W-1:0] cnt_swr_i,
  input logic [CNT_W-1:0] cnt_acq_i,
  input logic [(1<<TAG_W)-1:0] busy_i
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic fire, spec, inc_ord, dec_ord;
  assign fire    = op_valid_i && op_ready_o;
  assign spec    = (op_label_i != 2'b00);
  assign inc_ord = fire && (op_label_i == 2'b00);
  assign dec_ord = done_valid_i && (done_label_i == 2'b00);

  assert_acq_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_acq_i != '0) |-> !op_ready_o);

  assert_rel_drain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op_label_i == 2'b11) |-> (cnt_ord_i == '0 && cnt_srd_i == '0 && cnt_swr_i == '0));

  assert_spec_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && spec && (!mode_pc_i || op_is_write_i)) |-> (cnt_srd_i == '0 && cnt_swr_i == '0));

  assert_pc_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && spec) |-> (cnt_srd_i == '0));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ord_i == CntMax && op_label_i == 2'b00) |-> !op_ready_o);

  assert_tag_unique_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i[op_tag_i] |-> !op_ready_o);

  assert_count_up_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_ord && !dec_ord && cnt_ord_i != CntMax) |=> (cnt_ord_i == $past(cnt_ord_i) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_ord && dec_ord) |=> $stable(cnt_ord_i));
endmodule

bind rc_order_gate rc_order_gate_chk #(.CNT_W(CNT_W), .TAG_W(TAG_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_pc_i     (mode_pc_i),
  .op_valid_i    (op_valid_i),
  .op_ready_o    (op_ready_o),
  .op_label_i    (op_label_i),
  .op_is_write_i (op_is_write_i),
  .op_tag_i      (op_tag_i),
  .done_valid_i  (done_valid_i),
  .done_label_i  (done_label_i),
  .cnt_ord_i     (cnt_ord),
  .cnt_srd_i     (cnt_srd),
  .cnt_swr_i     (cnt_swr),
  .cnt_acq_i     (cnt_acq),
  .busy_i        (busy_v)
);

// File: tb/rc_order_gate_tb_top.sv
`timescale 1ns/1ps
module rc_order_gate_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_pc_i = 1'b0;
  logic       op_valid_i = 1'b0;
  logic       op_ready_o;
  logic [1:0] op_label_i = 2'b00;
  logic       op_is_write_i = 1'b0;
  logic [3:0] op_tag_i = 4'd0;
  logic       done_valid_i = 1'b0;
  logic [3:0] done_tag_i = 4'd0;
  logic [1:0] done_label_i = 2'b00;
  logic       done_is_write_i = 1'b0;

  always #4 clk_i = ~clk_i;

  rc_order_gate dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_pc_i(mode_pc_i),
    .op_valid_i(op_valid_i), .op_ready_o(op_ready_o), .op_label_i(op_label_i),
    .op_is_write_i(op_is_write_i), .op_tag_i(op_tag_i),
    .done_valid_i(done_valid_i), .done_tag_i(done_tag_i),
    .done_label_i(done_label_i), .done_is_write_i(done_is_write_i)
  );

  int total = 0;
  int bad = 0;
  logic       m_busy [16];
  logic [1:0] m_lab  [16];
  logic       m_wr   [16];

  // expected readiness straight from the requirements
  function automatic logic exp_ready(input logic [1:0] lab, input logic wr, input logic [3:0] tag);
    int n_ord = 0, n_srd = 0, n_swr = 0, n_acq = 0;
    logic spec;
    for (int t = 0; t < 16; t++) if (m_busy[t]) begin
      if (m_lab[t] == 2'b00) n_ord++;
      else if (m_wr[t]) n_swr++;
      else n_srd++;
      if (m_lab[t] == 2'b10) n_acq++;
    end
    spec = (lab != 2'b00);
    if (n_acq > 0) return 1'b0;                                     // R3
    if (m_busy[tag]) return 1'b0;                                   // R9
    if (!spec && n_ord >= 15) return 1'b0;                          // R8
    if (spec && !wr && n_srd >= 15) return 1'b0;
    if (spec && wr && n_swr >= 15) return 1'b0;
    if (spec && n_srd > 0) return 1'b0;                             // R5 R6
    if (spec && n_swr > 0 && (!mode_pc_i || wr)) return 1'b0;
    if (lab == 2'b11 && (n_ord + n_srd + n_swr) > 0) return 1'b0;   // R4
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ready=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] lab, input logic wr, input logic [3:0] tag,
                      input logic dv, input logic [3:0] dtag, input string req);
    logic e;
    @(negedge clk_i);
    op_valid_i = v; op_label_i = lab; op_is_write_i = wr; op_tag_i = tag;
    done_valid_i = dv; done_tag_i = dtag;
    done_label_i = m_lab[dtag]; done_is_write_i = m_wr[dtag];
    #1;
    e = exp_ready(lab, wr, tag);
    check(op_ready_o, e, req);
    @(posedge clk_i);
    if (dv) m_busy[dtag] = 1'b0;
    if (v && e) begin m_busy[tag] = 1'b1; m_lab[tag] = lab; m_wr[tag] = wr; end
    #1;
    op_valid_i = 1'b0; done_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int t = 0; t < 16; t++)
      if (m_busy[t]) step(1'b0, 2'b00, 1'b0, 4'd0, 1'b1, 4'(t), "R10");
  endtask

  function automatic string probe_req(input logic [1:0] lab);
    if (lab == 2'b11) return "R4";
    if (lab == 2'b10) return "R7";
    if (lab == 2'b01) return mode_pc_i ? "R6" : "R5";
    return "R2";
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 16; t++) begin m_busy[t] = 0; m_lab[t] = 0; m_wr[t] = 0; end
    #20 rst_ni = 1'b1;
    // R1: reset state, every label and direction ready
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < 2; w++)
        step(1'b0, 2'(l), 1'(w), 4'd0, 1'b0, 4'd0, "R1");

    // sweep outstanding ord/srd/swr state against every head in both modes
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 8; s++)
        for (int l = 0; l < 4; l++)
          for (int w = 0; w < 2; w++) begin
            mode_pc_i = 1'b1;
            if (s[0]) step(1'b1, 2'b00, 1'b0, 4'd0, 1'b0, 4'd0, "R2");
            if (s[2]) step(1'b1, 2'b01, 1'b1, 4'd1, 1'b0, 4'd0, "R6");
            if (s[1]) step(1'b1, 2'b01, 1'b0, 4'd2, 1'b0, 4'd0, "R6");
            mode_pc_i = 1'(md);
            step(1'b0, 2'(l), 1'(w), 4'd5, 1'b0, 4'd0, probe_req(2'(l)));
            drain();
          end

    // R3: acquire blocks everything until its completion has been taken
    mode_pc_i = 1'b0;
    step(1'b1, 2'b10, 1'b0, 4'd1, 1'b0, 4'd0, "R3");
    step(1'b1, 2'b00, 1'b0, 4'd2, 1'b0, 4'd0, "R3");
    step(1'b1, 2'b11, 1'b1, 4'd2, 1'b0, 4'd0, "R3");
    step(1'b1, 2'b00, 1'b0, 4'd2, 1'b1, 4'd1, "R3");
    step(1'b1, 2'b00, 1'b0, 4'd2, 1'b0, 4'd0, "R3");
    drain();

    // R8: saturation of the ordinary counter
    for (int t = 0; t < 15; t++) step(1'b1, 2'b00, 1'b0, 4'(t), 1'b0, 4'd0, "R8");
    step(1'b1, 2'b00, 1'b0, 4'd15, 1'b0, 4'd0, "R8");
    step(1'b0, 2'b01, 1'b1, 4'd15, 1'b1, 4'd0, "R8");
    step(1'b1, 2'b00, 1'b0, 4'd15, 1'b0, 4'd0, "R8");
    drain();

    // R9: tag reuse
    step(1'b1, 2'b00, 1'b0, 4'd3, 1'b0, 4'd0, "R9");
    step(1'b1, 2'b00, 1'b0, 4'd3, 1'b0, 4'd0, "R9");
    step(1'b1, 2'b00, 1'b0, 4'd4, 1'b1, 4'd3, "R9");
    step(1'b1, 2'b00, 1'b0, 4'd3, 1'b0, 4'd0, "R9");
    drain();

    // R10: issue and completion in the same cycle
    step(1'b1, 2'b00, 1'b0, 4'd0, 1'b0, 4'd0, "R10");
    step(1'b1, 2'b00, 1'b0, 4'd1, 1'b1, 4'd0, "R10");
    step(1'b0, 2'b11, 1'b1, 4'd5, 1'b0, 4'd0, "R10");
    step(1'b0, 2'b11, 1'b1, 4'd5, 1'b1, 4'd1, "R10");
    step(1'b0, 2'b11, 1'b1, 4'd5, 1'b0, 4'd0, "R10");

    // random stream, random completion order, both modes
    for (int md = 0; md < 2; md++) begin
      mode_pc_i = 1'(md);
      for (int i = 0; i < 4000; i++) begin
        logic dv;
        logic [3:0] dt;
        int st;
        dv = 1'b0; dt = 4'd0;
        st = $urandom_range(0, 15);
        if ($urandom_range(0, 1) == 1)
          for (int k = 0; k < 16; k++)
            if (!dv && m_busy[(st + k) % 16]) begin dv = 1'b1; dt = 4'((st + k) % 16); end
        step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             4'($urandom_range(0, 15)), dv, dt, md ? "R6" : "R5");
      end
      drain();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule